// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block models the logic of a serial configuration memory that supplies a bitstream to a programmable logic device, one bit per clock. The device being configured drives it directly. It supplies the clock, an active-low chip select and a combined reset/output-enable pin, and it reads back a single data line. That data line is a tri-state pin, modelled here as a data output plus a separate output-enable.

Inside, an address counter indexes a bit image of parameterised length. The image is fixed at elaboration from a seed constant. While the reset/output-enable pin is low, the counter is cleared and the data line is released, whatever the chip select does. With reset/output-enable high and chip select low, one bit is presented per cycle and the counter steps forward. With chip select high, everything pauses.

Once every stored bit has gone out, the block releases the data line and pulls its active-low cascade output low. A following device in a chain can then take over without two drivers fighting on the line. A synchronous power-on reset input stands in for the power-up clear.

Top module: `cfg_bit_streamer`

## Requirements
- R1: While `rst_oe` is low, `dout_oe` is 0. At the next rising edge the counter is cleared, so the first bit driven after release is image bit 0.
- R2: A low `rst_oe` clears the counter and releases the line even while `cs_n` is low.
- R3: With `rst_oe` high and `cs_n` high, `dout_oe` is 0 and the counter holds its value. The stream later resumes at the bit where it paused.
- R4: With `rst_oe` high, `cs_n` low and the end not yet reached, `dout_oe` is 1 and `dout` shows the bit at the current address. The address advances by one on each rising clock edge.
- R5: After the rising edge at which bit DEPTH-1 is presented, `casc_n` goes low and `dout_oe` is 0. Exactly DEPTH bits are ever driven between two clears.
- R6: Once the end is reached, the counter stops and `casc_n` stays low whatever `cs_n` does. Only an `rst_oe` low level returns `casc_n` high, at the next rising edge.
- R7: `por` high at a rising edge clears the counter and returns `casc_n` high.
- R8: Image bit i is the XOR reduction of the 32-bit value (i * 32'h9E3779B1) XOR SEED. Whenever `dout_oe` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock from the device being configured |
| por | input | 1 | Synchronous power-on reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rst_oe | input | 1 | Low: clear counter and release line; high: output enabled |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Drive enable for the data line |
| casc_n | output | 1 | Cascade hand-off, low once all data has been sent |

## Verification
The hardest state to reach is the exact end of the image after the stream has been paused, resumed and restarted. Once there, the bench must hold the block at its saturation point while chip select keeps toggling. The stimulus table walks a restart in mid-stream, several pauses and one long enabled run well past DEPTH cycles. A reference model built from the requirements predicts the cycle at which `casc_n` falls. The bench then toggles chip select inside the saturated state and clears it with a reset/output-enable pulse. It also applies a power-on reset in mid-stream.

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer #(
  parameter int          DEPTH = 512,
  parameter logic [31:0] SEED  = 32'h1D2C_3B4A
) (
  input  logic clk,
  input  logic por,
  input  logic cs_n,
  input  logic rst_oe,
  output logic dout,
  output logic dout_oe,
  output logic casc_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [DEPTH-1:0] build_image();
    logic [DEPTH-1:0] img;
    for (int i = 0; i < DEPTH; i++)
      img[i] = ^((32'(i) * 32'h9E3779B1) ^ SEED);
    return img;
  endfunction

  localparam logic [DEPTH-1:0] IMAGE = build_image();

  logic [AW-1:0] addr;
  logic          done;
  logic          run;

  assign run = rst_oe & ~cs_n & ~done;

  always_ff @(posedge clk) begin
    if (por || !rst_oe) begin
      addr <= '0;
      done <= 1'b0;
    end else if (run) begin
      if (addr == LAST) done <= 1'b1;
      else              addr <= addr + 1'b1;
    end
  end

  assign dout_oe = run;
  assign dout    = run & IMAGE[addr];
  assign casc_n  = ~done;
endmodule

module cfg_bit_streamer_chk #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input logic          clk,
  input logic          por,
  input logic          cs_n,
  input logic          rst_oe,
  input logic          dout,
  input logic          dout_oe,
  input logic          casc_n,
  input logic [AW-1:0] addr,
  input logic          done
);
  p_reset_release_r1: assert property (@(posedge clk) disable iff (por)
    !rst_oe |-> !dout_oe);
  p_reset_clear_r2: assert property (@(posedge clk) disable iff (por)
    !rst_oe |=> (addr == '0) && casc_n);
  p_hold_r3: assert property (@(posedge clk) disable iff (por)
    (rst_oe && cs_n) |=> $stable(addr) && !$past(dout_oe));
  p_advance_r4: assert property (@(posedge clk) disable iff (por)
    (rst_oe && !cs_n && casc_n && addr != AW'(DEPTH - 1)) |=> addr == $past(addr) + 1'b1);
  p_eod_release_r5: assert property (@(posedge clk) disable iff (por)
    !casc_n |-> !dout_oe);
  p_saturate_r6: assert property (@(posedge clk) disable iff (por)
    (rst_oe && !casc_n) |=> !casc_n && $stable(addr));
  p_por_clear_r7: assert property (@(posedge clk)
    por |=> (addr == '0) && !done);
  p_quiet_r8: assert property (@(posedge clk) disable iff (por)
    !dout_oe |-> !dout);
endmodule

bind cfg_bit_streamer cfg_bit_streamer_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .por(por), .cs_n(cs_n), .rst_oe(rst_oe), .dout(dout),
  .dout_oe(dout_oe), .casc_n(casc_n), .addr(addr), .done(done)
);

// File: tb/test_cfg_bit_streamer.sv
module test_cfg_bit_streamer;
  localparam int          DEPTH = 512;
  localparam logic [31:0] SEED  = 32'h1D2C_3B4A;

  typedef struct packed {
    logic        oe_in;
    logic        csn_in;
    logic [15:0] cycles;
  } phase_t;

  localparam int NPH = 11;
  localparam phase_t PHASES [NPH] = '{
    '{1'b0, 1'b1, 16'd3},
    '{1'b1, 1'b1, 16'd5},
    '{1'b1, 1'b0, 16'd100},
    '{1'b1, 1'b1, 16'd7},
    '{1'b1, 1'b0, 16'd50},
    '{1'b0, 1'b0, 16'd4},
    '{1'b1, 1'b0, 16'd600},
    '{1'b1, 1'b1, 16'd3},
    '{1'b1, 1'b0, 16'd5},
    '{1'b0, 1'b1, 16'd2},
    '{1'b1, 1'b0, 16'd10}
  };

  logic clk = 1'b0;
  logic por = 1'b1, cs_n = 1'b1, rst_oe = 1'b1;
  logic dout, dout_oe, casc_n;
  int   n_vec = 0, n_bad = 0;
  int   m_addr = 0;
  bit   m_done = 1'b0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  cfg_bit_streamer #(.DEPTH(DEPTH), .SEED(SEED)) i_cfg_bit_streamer (
    .clk(clk), .por(por), .cs_n(cs_n), .rst_oe(rst_oe),
    .dout(dout), .dout_oe(dout_oe), .casc_n(casc_n)
  );

  function automatic logic img_bit(int i);
    return ^((32'(i) * 32'h9E3779B1) ^ SEED);
  endfunction

  task automatic cmp(string tag, logic act, logic exp, string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(logic p, logic oe_in, logic csn_in, string force_tag);
    logic e_oe, e_d, e_c;
    string tag;
    @(negedge clk);
    por = p; rst_oe = oe_in; cs_n = csn_in;
    #1;
    e_oe = oe_in && !csn_in && !m_done;
    e_d  = e_oe ? img_bit(m_addr) : 1'b0;
    e_c  = !m_done;
    if (force_tag != "")  tag = force_tag;
    else if (!oe_in)      tag = "R1";
    else if (m_done)      tag = "R6";
    else if (csn_in)      tag = "R3";
    else                  tag = "R4";
    cmp(tag, dout_oe, e_oe, "dout_oe");
    cmp(e_oe ? tag : "R8", dout, e_d, "dout");
    cmp(m_done ? "R5" : tag, casc_n, e_c, "casc_n");
    if (p || !oe_in) begin
      m_addr = 0; m_done = 1'b0;
    end else if (e_oe) begin
      if (m_addr == DEPTH - 1) m_done = 1'b1;
      else m_addr++;
    end
  endtask

  initial begin
    int driven;
    step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b1, "R7");
    cmp("R7", casc_n, 1'b1, "casc_n after por");
    cmp("R7", dout_oe, 1'b0, "dout_oe after por, cs_n high");

    for (int p = 0; p < NPH; p++)
      for (int c = 0; c < int'(PHASES[p].cycles); c++)
        step(1'b0, PHASES[p].oe_in, PHASES[p].csn_in, "");

    step(1'b0, 1'b0, 1'b1, "R1");
    for (int c = 0; c < 30; c++) step(1'b0, 1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b0, "R2");
    cmp("R2", dout_oe, 1'b0, "dout_oe with rst_oe low, cs_n low");
    step(1'b0, 1'b1, 1'b0, "R2");
    cmp("R2", dout, img_bit(0), "first bit after override");

    driven = 1;
    for (int c = 0; c < DEPTH + 20; c++) begin
      step(1'b0, 1'b1, 1'b0, "");
      if (dout_oe) driven++;
    end
    cmp("R5", 1'(driven == DEPTH), 1'b1, "exactly DEPTH bits driven");
    cmp("R5", casc_n, 1'b0, "casc_n at end of data");
    for (int c = 0; c < 6; c++) step(1'b0, 1'b1, 1'(c % 2), "R6");
    cmp("R6", casc_n, 1'b0, "casc_n held after cs_n toggles");
    step(1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, 1'b1, "R6");
    cmp("R6", casc_n, 1'b1, "casc_n back high after rst_oe pulse");

    for (int c = 0; c < 12; c++) step(1'b0, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");
    cmp("R7", dout, img_bit(0), "stream restarts at bit 0 after por");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule